// File: doc/BRIEF.md
# Masked burst address counter

This block generates the address for one port of a synchronous memory. On a clock edge it can take an address from outside, step forward by one on its own, or clear its counting bits. A mask register chooses how many low-order address bits count. The bits above the mask keep the value they were loaded with, so a burst stays inside an aligned block whose size the mask sets. An active-low interrupt tells the port when the counting bits have reached all ones.

A select input switches the address interface between the counter and the mask register. While the mask is selected, the strobe writes the external address into the mask, and the counter holds its value. A readback bus shows the counter, or the mask when the mask is selected. An asynchronous master reset puts the block in a known state. One master reset is required after power-up.

Top module: `masked_burst_counter`

## Requirements
- R1: In counter mode (`maskSelN` high) with `cntClrN` high, a rising edge with `strobeN` low and `cntEnN` low loads `extAddr` into `curAddr`.
- R2: In counter mode with `cntClrN` high, `strobeN` high and `cntEnN` low, each rising edge adds one to the bits of `curAddr` where the mask is 1, wrapping within those bits. Bits where the mask is 0 keep their value.
- R3: In counter mode, `cntClrN` low on a rising edge clears the bits of `curAddr` where the mask is 1 and keeps the others. This happens whatever `strobeN` and `cntEnN` are, so clear wins over load and increment.
- R4: `wrapIntN` goes low on the increment edge that makes every masked bit of `curAddr` equal to 1. It stays low through later increments and returns high on the next load or clear edge. With an all-zero mask, every increment edge drives it low.
- R5: With the mask all ones, the counter steps through every address and goes from the top address back to 0.
- R6: In mask mode (`maskSelN` low), `strobeN` low on a rising edge writes the mask. The value stored is the run of ones at the bottom of `extAddr`: bit i is set only when `extAddr` bits i down to 0 are all 1. So the stored mask is always a contiguous run of ones starting at bit 0.
- R7: In mask mode, `curAddr` and `wrapIntN` do not change, whatever `cntClrN`, `cntEnN` and `strobeN` are.
- R8: `readback` equals `curAddr` when `maskSelN` is high and the mask register when `maskSelN` is low. It follows the select with no clock delay.
- R9: Master reset (`rstN` low) sets the mask to all ones, `curAddr` to 0 and `wrapIntN` high.
- R10: In counter mode with `cntClrN` high, `strobeN` low and `cntEnN` high, a rising edge leaves `curAddr` and `wrapIntN` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; the block acts on rising edges |
| rstN | input | 1 | Asynchronous master reset, active low |
| strobeN | input | 1 | Address strobe, active low: load in counter mode, mask write in mask mode |
| cntEnN | input | 1 | Counter enable, active low |
| cntClrN | input | 1 | Clear of the masked counter bits, active low |
| maskSelN | input | 1 | Low selects the mask register instead of the counter |
| extAddr | input | ADDR_W | External address, or the mask value to write |
| curAddr | output | ADDR_W | Current internal address |
| readback | output | ADDR_W | Counter value, or mask value when the mask is selected |
| wrapIntN | output | 1 | Wrap interrupt, active low |

## Verification
The bench uses a 6-bit configuration. It sets every contiguous mask width from zero to full. For each width it loads a base address that has upper bits set, then increments past the wrap point. A design that carried into the masked-off bits would move the burst out of its block, and one that compared the whole address would raise the interrupt at the wrong edge or never. Clear is driven with load requested at the same time, and a wrong priority shows up as the external address appearing on `curAddr`. Mask writes use values with gaps in the run of ones, and counter controls are toggled while the mask is selected. A design that stored the raw value, or that let the counter move in mask mode, gives a wrong readback or a shifted address.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Per-edge commands from control to datapath; at most one is active.
  typedef struct packed {
    logic clear;
    logic load;
    logic incr;
    logic maskWr;
  } burstStrobes_t;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_pkg::*;
(
  input  logic          strobeN,
  input  logic          cntEnN,
  input  logic          cntClrN,
  input  logic          maskSelN,
  output burstStrobes_t stb
);
  logic cntMode;

  assign cntMode = maskSelN;

  always_comb begin
    stb        = '0;
    stb.maskWr = !cntMode && !strobeN;
    if (cntMode) begin
      if (!cntClrN)
        stb.clear = 1'b1;          // clear beats load and increment
      else if (!cntEnN)
        begin
          stb.load = !strobeN;
          stb.incr = strobeN;
        end
    end
  end
endmodule

// File: rtl/burst_path.sv
module burst_path
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobes_t     stb,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] cntQ,
  output logic [ADDR_W-1:0] maskQ,
  output logic              wrapN
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] maskIn;
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] clearVal;
  logic              hitsTop;

  // Keep only the run of ones that starts at bit 0.
  assign maskIn[0] = extAddr[0];
  for (genvar i = 1; i < ADDR_W; i++) begin : g_smear
    assign maskIn[i] = maskIn[i-1] & extAddr[i];
  end

  assign stepVal  = (cntQ & ~maskQ) | ((cntQ + ONE) & maskQ);
  assign clearVal = cntQ & ~maskQ;
  assign hitsTop  = (stepVal & maskQ) == maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      maskQ <= '1;
      wrapN <= 1'b1;
    end else begin
      if (stb.maskWr) maskQ <= maskIn;
      if (stb.clear) begin
        cntQ  <= clearVal;
        wrapN <= 1'b1;
      end else if (stb.load) begin
        cntQ  <= extAddr;
        wrapN <= 1'b1;
      end else if (stb.incr) begin
        cntQ <= stepVal;
        if (hitsTop) wrapN <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/masked_burst_counter.sv
module masked_burst_counter #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeN,
  input  logic              cntEnN,
  input  logic              cntClrN,
  input  logic              maskSelN,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] readback,
  output logic              wrapIntN
);
  burst_pkg::burstStrobes_t stb;
  logic [ADDR_W-1:0] cntQ;
  logic [ADDR_W-1:0] maskQ;

  burst_ctl ctl_i (
    .strobeN (strobeN),
    .cntEnN  (cntEnN),
    .cntClrN (cntClrN),
    .maskSelN(maskSelN),
    .stb     (stb)
  );

  burst_path #(.ADDR_W(ADDR_W)) path_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .extAddr(extAddr),
    .cntQ   (cntQ),
    .maskQ  (maskQ),
    .wrapN  (wrapIntN)
  );

  assign curAddr  = cntQ;
  assign readback = maskSelN ? cntQ : maskQ;
endmodule

// File: rtl/masked_burst_counter_chk.sv
module masked_burst_counter_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              strobeN,
  input logic              cntEnN,
  input logic              cntClrN,
  input logic              maskSelN,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] curAddr,
  input logic [ADDR_W-1:0] readback,
  input logic              wrapIntN,
  input logic [ADDR_W-1:0] maskQ
);
  assert_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (maskSelN && cntClrN && !strobeN && !cntEnN) |=> curAddr == $past(extAddr));

  assert_upper_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (maskSelN && cntClrN && strobeN && !cntEnN)
      |=> (curAddr & ~maskQ) == ($past(curAddr) & ~maskQ));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (maskSelN && !cntClrN)
      |=> ((curAddr & maskQ) == '0) && wrapIntN);

  assert_wrap_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrapIntN) |-> (curAddr & maskQ) == maskQ);

  assert_mask_shape_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((maskQ + ADDR_W'(1)) & maskQ) == '0);

  assert_mask_mode_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !maskSelN |=> $stable(curAddr) && $stable(wrapIntN));

  assert_readback_R8: assert property (@(posedge clk) disable iff (!rstN)
    readback == (maskSelN ? curAddr : maskQ));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (maskSelN && cntClrN && !strobeN && cntEnN)
      |=> $stable(curAddr) && $stable(wrapIntN));
endmodule

bind masked_burst_counter masked_burst_counter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .strobeN (strobeN),
  .cntEnN  (cntEnN),
  .cntClrN (cntClrN),
  .maskSelN(maskSelN),
  .extAddr (extAddr),
  .curAddr (curAddr),
  .readback(readback),
  .wrapIntN(wrapIntN),
  .maskQ   (maskQ)
);

// File: tb/masked_burst_counter_tb_top.sv
`timescale 1ns/1ps
module masked_burst_counter_tb_top;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          strobeN = 1'b1, cntEnN = 1'b1, cntClrN = 1'b1, maskSelN = 1'b1;
  logic [AW-1:0] extAddr = '0;
  logic [AW-1:0] curAddr, readback;
  logic          wrapIntN;

  int checks = 0;
  int fails  = 0;

  logic [AW-1:0] expCnt  = '0;
  logic [AW-1:0] expMask = '1;
  logic          expWrap = 1'b1;

  always #4 clk = ~clk;

  masked_burst_counter #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .strobeN(strobeN), .cntEnN(cntEnN),
    .cntClrN(cntClrN), .maskSelN(maskSelN), .extAddr(extAddr),
    .curAddr(curAddr), .readback(readback), .wrapIntN(wrapIntN)
  );

  task automatic chk(input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, sample after the rising edge.
  task automatic step(input logic s, input logic e, input logic c, input logic m,
                      input logic [AW-1:0] a, input string req);
    @(negedge clk);
    strobeN = s; cntEnN = e; cntClrN = c; maskSelN = m; extAddr = a;
    if (m) begin
      if (!c) begin
        expCnt = expCnt & ~expMask; expWrap = 1'b1;
      end else if (!e && !s) begin
        expCnt = a; expWrap = 1'b1;
      end else if (!e && s) begin
        expCnt = (expCnt & ~expMask) | ((expCnt + AW'(1)) & expMask);
        if ((expCnt & expMask) == expMask) expWrap = 1'b0;
      end
    end else if (!s) begin
      expMask = ((a + AW'(1)) & ~a) - AW'(1);
    end
    @(posedge clk); #1;
    chk(req, "curAddr", curAddr, expCnt);
    chk(req, "readback", readback, m ? expCnt : expMask);
    chk(req, "wrapIntN", AW'(wrapIntN), AW'(expWrap));
  endtask

  initial begin : watchdog
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #10;
    // R9: master reset state
    chk("R9", "curAddr", curAddr, '0);
    chk("R9", "wrapIntN", AW'(wrapIntN), AW'(1));
    maskSelN = 1'b0; #1;
    chk("R9", "mask", readback, '1);
    chk("R8", "mask readback", readback, '1);
    maskSelN = 1'b1;
    #5 rstN = 1'b1;

    // R5: full range with mask all ones, wrap to zero
    step(1'b0, 1'b0, 1'b1, 1'b1, '0, "R1");
    for (int n = 0; n < 66; n++) step(1'b1, 1'b0, 1'b1, 1'b1, '0, "R5");
    step(1'b0, 1'b0, 1'b1, 1'b1, 6'h15, "R4");

    // R2/R4/R6: every contiguous mask width
    for (int k = 0; k <= AW; k++) begin
      logic [AW-1:0] mv;
      mv = AW'((1 << k) - 1);
      step(1'b0, 1'b1, 1'b1, 1'b0, mv, "R6");
      step(1'b0, 1'b0, 1'b1, 1'b1, 6'h2D, "R1");
      for (int n = 0; n < (1 << k) + 2; n++)
        step(1'b1, 1'b0, 1'b1, 1'b1, '0, "R2");
      // R3: clear with load also requested
      step(1'b0, 1'b0, 1'b0, 1'b1, 6'h3F, "R3");
    end

    // R6: gapped values keep only the low run
    step(1'b0, 1'b1, 1'b1, 1'b0, 6'b101011, "R6");
    step(1'b0, 1'b1, 1'b1, 1'b0, 6'b111110, "R6");
    step(1'b0, 1'b1, 1'b1, 1'b0, 6'b000111, "R6");

    // R7: counter controls ignored in mask mode
    step(1'b0, 1'b0, 1'b1, 1'b1, 6'h26, "R1");
    step(1'b1, 1'b0, 1'b1, 1'b1, '0, "R2");
    step(1'b1, 1'b0, 1'b1, 1'b0, 6'h11, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, 6'h11, "R7");
    step(1'b1, 1'b1, 1'b0, 1'b0, 6'h11, "R7");

    // R10: strobe without enable holds
    step(1'b0, 1'b1, 1'b1, 1'b1, 6'h3A, "R10");
    step(1'b1, 1'b1, 1'b1, 1'b1, 6'h3A, "R10");

    // R4: interrupt held through increments, cleared by clear
    step(1'b0, 1'b0, 1'b1, 1'b1, 6'h0E, "R1");
    step(1'b1, 1'b0, 1'b1, 1'b1, '0, "R4");
    step(1'b1, 1'b0, 1'b1, 1'b1, '0, "R4");
    step(1'b0, 1'b1, 1'b0, 1'b1, '0, "R3");

    // R8: readback follows select without a clock
    @(negedge clk); maskSelN = 1'b0; #1;
    chk("R8", "mask readback", readback, expMask);
    maskSelN = 1'b1; #1;
    chk("R8", "counter readback", readback, expCnt);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule